// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This unit decides whether a conditional trap instruction fires. Each cycle it takes the already decoded trap form (register against register, or register against immediate), a 3-bit condition selector, the two 32-bit register operands and a 16-bit immediate field. It returns a trap request and an illegal-encoding flag. Both outputs are registered, so they appear one clock after the inputs are sampled.

A single shared comparator works out the equal, signed less-than and unsigned less-than relations between rs and the second operand. The second operand is either rt or the immediate, which is sign-extended to the full data width. The selector then picks one of six conditions from those three relations. Two selector values have no defined trap. For those values the unit flags an illegal encoding and never requests a trap. Building the exception vector, updating the exception program counter and checking privilege are left to the pipeline around it.

Top module: `trapeval_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both `trap_req` and `illegal_enc` are 0 after that edge, whatever the other inputs are.
- R2: Selector 0 requests a trap when rs is greater than or equal to the second operand, both read as two's-complement signed numbers.
- R3: Selector 1 requests a trap when rs is greater than or equal to the second operand, both read as unsigned numbers.
- R4: Selector 2 requests a trap when rs is less than the second operand under signed comparison. 0x80000000 is the smallest value and 0x7FFFFFFF the largest.
- R5: Selector 3 requests a trap when rs is less than the second operand under unsigned comparison. 0xFFFFFFFF is the largest value and 0 the smallest.
- R6: Selector 4 requests a trap when rs equals the second operand, and selector 6 requests one when they differ.
- R7: When `form_imm` is 1, the second operand is the 16-bit immediate sign-extended to 32 bits, for the unsigned conditions as well as the signed ones, and `rt_val` has no effect. When `form_imm` is 0, the second operand is `rt_val` and `imm_val` has no effect.
- R8: With `instr_valid` high, selectors 5 and 7 set `illegal_enc` to 1 and `trap_req` to 0. Selectors 0 to 4 and 6 leave `illegal_enc` at 0.
- R9: With `instr_valid` low, both outputs are 0 after the next edge, whatever the operands and selector are.
- R10: The outputs reflect the inputs sampled at the previous rising edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A trap instruction is present this cycle |
| form_imm | input | 1 | 0: compare rs with rt; 1: compare rs with the sign-extended immediate |
| cond_sel | input | 3 | Condition selector (0 sge, 1 uge, 2 slt, 3 ult, 4 eq, 6 ne; 5 and 7 illegal) |
| rs_val | input | 32 | First operand |
| rt_val | input | 32 | Second operand for the register form |
| imm_val | input | 16 | Immediate field for the immediate form |
| trap_req | output | 1 | Registered trap request |
| illegal_enc | output | 1 | Registered illegal-encoding flag |

## Verification
Every selector is driven with operand pairs placed at the edges of the number line. These are 0x80000000 against 0x7FFFFFFF, 0xFFFFFFFF against 0, equal extremes, and neighbours that differ by one. The pairs where the signed and unsigned orders disagree separate a signed comparison from an unsigned one. The equal pairs separate greater-or-equal from greater-than.

The immediate form uses the immediates 0xFFFF, 0x8000, 0x7FFF and 0, with a misleading rt value. This shows whether the extension is signed for the unsigned conditions too, and whether the form bit really picks the operand. The register form carries a misleading immediate for the same reason.

Cycles with `instr_valid` low carry trap-true operands, and cycles with selectors 5 and 7 carry trap-true operands. These show that neither can leak a trap request.

// File: rtl/trapeval_pkg.sv
package trapeval_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    COND_SGE  = 3'd0,
    COND_UGE  = 3'd1,
    COND_SLT  = 3'd2,
    COND_ULT  = 3'd3,
    COND_EQ   = 3'd4,
    COND_RSV5 = 3'd5,
    COND_NE   = 3'd6,
    COND_RSV7 = 3'd7
  } cond_e;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } rel_t;
endpackage

// File: rtl/trapeval_opsel.sv
module trapeval_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              form_imm,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_noext
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = form_imm ? imm_ext : rt_val;
endmodule

// File: rtl/trapeval_cmp.sv
module trapeval_cmp
  import trapeval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output rel_t              rel
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] diff;

  // One subtractor gives the borrow for the unsigned order. The sign bits
  // then fold that borrow into the signed order.
  assign diff     = {1'b0, opnd_a} - {1'b0, opnd_b};
  assign rel.lt_u = diff[DATA_W];
  assign rel.lt_s = diff[DATA_W] ^ opnd_a[MSB] ^ opnd_b[MSB];
  assign rel.eq   = (diff[DATA_W-1:0] == '0);

  // R6: equal operands are never ordered below one another
  always_comb begin
    assert_eq_excl_R6: assert (!(rel.eq && (rel.lt_s || rel.lt_u)));
  end
endmodule

// File: rtl/trapeval_cond.sv
module trapeval_cond
  import trapeval_pkg::*;
(
  input  logic [SEL_W-1:0] cond_sel,
  input  rel_t             rel,
  output logic             hit,
  output logic             illegal
);
  always_comb begin
    hit     = 1'b0;
    illegal = 1'b0;
    case (cond_e'(cond_sel))
      COND_SGE: hit = ~rel.lt_s;
      COND_UGE: hit = ~rel.lt_u;
      COND_SLT: hit = rel.lt_s;
      COND_ULT: hit = rel.lt_u;
      COND_EQ:  hit = rel.eq;
      COND_NE:  hit = ~rel.eq;
      default:  illegal = 1'b1;
    endcase
  end

  // R8: the reserved selectors never produce a condition hit
  always_comb begin
    assert_rsv_nohit_R8: assert (!(illegal && hit));
  end
endmodule

// File: rtl/trapeval_unit.sv
module trapeval_unit
  import trapeval_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic              form_imm,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic              trap_req,
  output logic              illegal_enc
);
  logic [DATA_W-1:0] opnd_b;
  rel_t              rel;
  logic              hit;
  logic              illegal;

  trapeval_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .form_imm (form_imm),
    .rt_val   (rt_val),
    .imm_val  (imm_val),
    .opnd_b   (opnd_b)
  );

  trapeval_cmp #(.DATA_W(DATA_W)) u_cmp (
    .opnd_a (rs_val),
    .opnd_b (opnd_b),
    .rel    (rel)
  );

  trapeval_cond u_cond (
    .cond_sel (cond_sel),
    .rel      (rel),
    .hit      (hit),
    .illegal  (illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req    <= 1'b0;
      illegal_enc <= 1'b0;
    end else begin
      trap_req    <= instr_valid & hit & ~illegal;
      illegal_enc <= instr_valid & illegal;
    end
  end

  // R1: reset clears both outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!trap_req && !illegal_enc));

  // R9: an idle cycle produces no flags
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!trap_req && !illegal_enc));

  // R8: reserved selectors flag illegal and never trap
  assert_rsv_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (cond_sel == 3'd5 || cond_sel == 3'd7))
      |=> (illegal_enc && !trap_req));

  // R4: a negative rs against a non-negative rt is always signed-less
  assert_slt_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !form_imm && cond_sel == 3'd2 &&
     rs_val[DATA_W-1] && !rt_val[DATA_W-1]) |=> trap_req);

  // R5: an all-ones rs is never unsigned-less than anything
  assert_ult_top_R5: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cond_sel == 3'd3 && (&rs_val)) |=> !trap_req);
endmodule

// File: tb/sim_trapeval_unit.sv
`timescale 1ns/1ps
module sim_trapeval_unit;
  typedef struct {
    logic  trap;
    logic  ill;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        form_imm = 1'b0;
  logic [2:0]  cond_sel = 3'd0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [15:0] imm_val = '0;
  logic        trap_req;
  logic        illegal_enc;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  trapeval_unit u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .form_imm(form_imm),
    .cond_sel(cond_sel), .rs_val(rs_val), .rt_val(rt_val), .imm_val(imm_val),
    .trap_req(trap_req), .illegal_enc(illegal_enc)
  );

  function automatic logic model_hit(input logic [2:0] s,
                                     input logic [31:0] a,
                                     input logic [31:0] b);
    case (s)
      3'd0:    return $signed(a) >= $signed(b);
      3'd1:    return a >= b;
      3'd2:    return $signed(a) < $signed(b);
      3'd3:    return a < b;
      3'd4:    return a == b;
      3'd6:    return a != b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string sel_tag(input logic [2:0] s, input logic imm);
    if (s == 3'd5 || s == 3'd7) return "R8";
    if (imm) return "R7";
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Driver: applies one instruction at a falling edge and queues its result
  task automatic drive(input logic v, input logic fi, input logic [2:0] s,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input string tag);
    exp_t e;
    logic [31:0] opb;
    instr_valid = v; form_imm = fi; cond_sel = s;
    rs_val = a; rt_val = b; imm_val = im;
    opb   = fi ? {{16{im[15]}}, im} : b;
    e.ill  = v && (s == 3'd5 || s == 3'd7);
    e.trap = v && model_hit(s, a, opb);
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: R10, each result is due one rising edge after its drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (trap_req !== e.trap || illegal_enc !== e.ill) begin
          errors++;
          $display("FAIL %s (R10 timing): trap=%b ill=%b expected trap=%b ill=%b",
                   e.tag, trap_req, illegal_enc, e.trap, e.ill);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa [10];
    logic [31:0] pb [10];
    logic [15:0] imv [4];
    pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
    pa[1] = 32'h8000_0000; pb[1] = 32'h7FFF_FFFF;
    pa[2] = 32'h7FFF_FFFF; pb[2] = 32'h8000_0000;
    pa[3] = 32'hFFFF_FFFF; pb[3] = 32'h0000_0000;
    pa[4] = 32'h0000_0000; pb[4] = 32'hFFFF_FFFF;
    pa[5] = 32'hFFFF_FFFF; pb[5] = 32'hFFFF_FFFF;
    pa[6] = 32'h8000_0000; pb[6] = 32'h8000_0000;
    pa[7] = 32'h0000_0001; pb[7] = 32'h0000_0000;
    pa[8] = 32'h0000_0005; pb[8] = 32'h0000_0006;
    pa[9] = 32'hFFFF_8000; pb[9] = 32'h0000_7FFF;
    imv[0] = 16'hFFFF; imv[1] = 16'h8000; imv[2] = 16'h7FFF; imv[3] = 16'h0000;

    // R1: reset holds outputs low under trap-true and illegal stimulus
    instr_valid = 1'b1; cond_sel = 3'd4; rs_val = 0; rt_val = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (trap_req !== 1'b0 || illegal_enc !== 1'b0) begin
      errors++;
      $display("FAIL R1: trap=%b ill=%b expected 0 0", trap_req, illegal_enc);
    end
    cond_sel = 3'd5;
    @(negedge clk);
    checks++;
    if (trap_req !== 1'b0 || illegal_enc !== 1'b0) begin
      errors++;
      $display("FAIL R1: trap=%b ill=%b expected 0 0", trap_req, illegal_enc);
    end
    rst = 1'b0;

    // Register form: every selector at the boundary pairs, misleading imm (R7)
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 10; i++) begin
        drive(1'b1, 1'b0, 3'(s), pa[i], pb[i], ~pa[i][15:0], sel_tag(3'(s), 1'b0));
      end
    end

    // Immediate form: sign extension for signed and unsigned, misleading rt (R7)
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 10; i++) begin
        for (int k = 0; k < 4; k++) begin
          drive(1'b1, 1'b1, 3'(s), pa[i], ~{{16{imv[k][15]}}, imv[k]}, imv[k],
                sel_tag(3'(s), 1'b1));
        end
      end
    end

    // R9: idle cycles with trap-true and reserved operands
    for (int s = 0; s < 8; s++) begin
      drive(1'b0, 1'b0, 3'(s), 32'h0, 32'h0, 16'h0, "R9");
      drive(1'b1, 1'b0, 3'd4, 32'h1234, 32'h1234, 16'h0, "R6");
      drive(1'b0, 1'b1, 3'(s), 32'hFFFF_FFFF, 32'h0, 16'hFFFF, "R9");
    end

    drive(1'b0, 1'b0, 3'd0, 32'h0, 32'h0, 16'h0, "R9");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule